// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives a single raw 8-bit NAND flash device through one complete transaction at a time. A host fills a small register set (a control word, a pair of opcodes, up to five address bytes and a byte count) and then sets a start bit. The engine walks the enabled phases, strobing each byte onto the device pins with parameterised low and high times, and raises a sticky end flag when it is done.

Each phase can be switched on or off on its own, and the address length can be programmed. One engine therefore covers page read, page program, block erase, ID read, status read and device reset. Payload bytes pass through a 32-bit word FIFO that the host fills or drains through a data register. The FIFO fill level can be read back, and a separate register empties the FIFO. After a second command the engine holds off until the ready/busy line returns high. A busy-time limit ends a stuck transaction with an error flag.

Host registers, selected by `reg_addr`: 0 control, 1 opcodes, 2 address low word, 3 fifth address byte, 4 count and level, 5 FIFO data, 6 FIFO clear. A register read returns data on `reg_rdata` one cycle after `reg_re`.

Top module: `nand_seq_top`

## Requirements
- R1: After reset the pins are idle (`nand_ce_n`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0), the control register reads 0 and the FIFO level reads 0.
- R2: Control bits 4, 5 and 6 enable the first-command, address and second-command phases. A phase that is disabled emits no bytes, and the next enabled phase follows it.
- R3: Opcode register bits 7:0 are the first command and bits 15:8 the second. Each command byte is strobed by one `nand_we_n` low pulse with `nand_cle`=1 and `nand_ale`=0.
- R4: Control bits 9:8 select 1 to 4 address bytes (encoded 0 to 3). Control bit 10 forces 5 bytes, the fifth taken from register 3 bits 7:0. Address bytes go out least significant byte first from register 2, each with `nand_ale`=1 and `nand_cle`=0.
- R5: Control bit 7 selects the data direction. With 1 (write), the data bytes go out on `nand_we_n` strobes between the address and the second command. With 0 (read), the data bytes are taken on `nand_re_n` strobes after the second command. The two strobes are never low together.
- R6: Register 4 bits 15:0 hold the byte count. A count of 0 runs no data phase and pulses no `nand_re_n`.
- R7: Control bit 1 (end) is set when a transaction finishes. It stays set through control writes of nonzero values and clears on a control write of 0 or on a new start (bit 0 written as 1).
- R8: Register 4 bits 23:16 read the FIFO level in words. A host write to register 5 pushes a word, a read pops one in order, and any write to register 6 empties the FIFO.
- R9: FIFO words are big-endian: the first flash byte sits in bits 31:24. On reads, a final partial word is left-aligned and padded with zero bytes.
- R10: Control bit 3 drives `nand_ce_n` low when set and high when clear.
- R11: After a second command the engine waits until `nand_rb_n` is high before starting a read data phase or finishing. If `nand_rb_n` stays low for BUSY_MAX cycles, control bit 2 (error) is set, the data phase is skipped and the end flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_re | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Host register select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid the cycle after `reg_re` |
| nand_ce_n | output | 1 | Device chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven to the device |
| nand_dq_oe | output | 1 | Drive enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Byte returned by the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench builds the block with an 8-word FIFO, a strobe low time of 2 cycles and a high time of 1, a 4-cycle ready-line blanking window, and a busy limit of 64 cycles. The short busy limit lets a device model that holds ready/busy low for 1000 cycles reach the timeout path within a short run. The small FIFO lets a 20-byte transfer fill most of the FIFO. The minimum strobe times make the byte ordering, phase skipping and ready-line hold-off visible on every cycle of the pin trace, which the bench logs and compares byte by byte.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_WAIT, S_DATA, S_END
  } seq_st_t;

  typedef enum logic [1:0] {
    PH_PREP, PH_LOAD, PH_LO, PH_HI
  } seq_ph_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_OPC  = 3'd1;
  localparam logic [2:0] RA_ADR  = 3'd2;
  localparam logic [2:0] RA_ADR2 = 3'd3;
  localparam logic [2:0] RA_CNT  = 3'd4;
  localparam logic [2:0] RA_FIFO = 3'd5;
  localparam logic [2:0] RA_CLR  = 3'd6;

  // control bits 10:3 as stored
  typedef struct packed {
    logic       five;
    logic [1:0] acnt;
    logic       dir;
    logic       cmd2_en;
    logic       addr_en;
    logic       cmd1_en;
    logic       ce;
  } seq_cfg_t;

endpackage

// File: rtl/nand_seq_fifo.sv
module nand_seq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // storage without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
    if (pop_ok)  rdata   <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH)); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0)); // R8

endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
  import nand_seq_pkg::*;
#(
  parameter int T_WLO    = 3,
  parameter int T_WHI    = 2,
  parameter int T_WB     = 4,
  parameter int BUSY_MAX = 100000,
  parameter int CNT_W    = 16,
  localparam int TMAX    = (T_WLO > T_WHI) ? ((T_WLO > T_WB) ? T_WLO : T_WB)
                                           : ((T_WHI > T_WB) ? T_WHI : T_WB),
  localparam int TW      = $clog2(TMAX + 1),
  localparam int BW      = $clog2(BUSY_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmd1_en,
  input  logic             addr_en,
  input  logic             cmd2_en,
  input  logic             dir,
  input  logic [1:0]       acnt,
  input  logic             five,
  input  logic [15:0]      opc,
  input  logic [31:0]      adr,
  input  logic [7:0]       adr2,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rb_n,
  input  logic [7:0]       dq_i,
  input  logic [31:0]      fifo_q,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  output logic             fifo_push,
  output logic [31:0]      fifo_wdata,
  output logic             fifo_pop,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq_o,
  output logic             dq_oe
);

  seq_st_t          st;
  seq_ph_t          ph;
  logic [TW-1:0]    tcnt;
  logic [BW-1:0]    bsy;
  logic [2:0]       aidx;
  logic [CNT_W-1:0] bdone;
  logic [31:0]      sh, asm_w;

  logic [2:0] n_adr;
  logic [1:0] widx;
  logic       last_adr, last_dat, rd_dat, wr_dat, word_end;
  logic [7:0] cur_byte;
  seq_st_t    to_first, to_addr, to_cmd2, to_data, after_addr, after_data, after_wait;

  assign n_adr    = five ? 3'd5 : {1'b0, acnt} + 3'd1;
  assign widx     = bdone[1:0];
  assign last_adr = (aidx == n_adr - 3'd1);
  assign last_dat = (bdone == cnt - 1'b1);
  assign rd_dat   = (st == S_DATA) && !dir;
  assign wr_dat   = (st == S_DATA) && dir;
  assign word_end = (widx == 2'd3) || last_dat;
  assign busy     = (st != S_IDLE);

  // phase ordering: writes place data before the confirm command
  always_comb begin
    if (dir) begin
      to_cmd2    = cmd2_en ? S_CMD2 : S_END;
      to_data    = (cnt != '0) ? S_DATA : to_cmd2;
      after_data = to_cmd2;
      after_wait = S_END;
      after_addr = to_data;
    end else begin
      to_data    = (cnt != '0) ? S_DATA : S_END;
      to_cmd2    = cmd2_en ? S_CMD2 : to_data;
      after_data = S_END;
      after_wait = to_data;
      after_addr = to_cmd2;
    end
    to_addr  = addr_en ? S_ADDR : after_addr;
    to_first = cmd1_en ? S_CMD1 : to_addr;
  end

  always_comb begin
    case (st)
      S_CMD1:  cur_byte = opc[7:0];
      S_CMD2:  cur_byte = opc[15:8];
      S_ADDR:  cur_byte = aidx[2] ? adr2 : adr[{aidx[1:0], 3'b000} +: 8];
      default: cur_byte = sh[31:24];
    endcase
  end

  assign fifo_pop   = wr_dat && (ph == PH_PREP) && (widx == 2'd0) && !fifo_empty;
  assign fifo_push  = rd_dat && (ph == PH_HI) && (tcnt == '0) && word_end && !fifo_full;
  assign fifo_wdata = asm_w << {(2'd3 - widx), 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      ph    <= PH_PREP;
      tcnt  <= '0;
      bsy   <= '0;
      aidx  <= '0;
      bdone <= '0;
      sh    <= '0;
      asm_w <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= to_first;
          ph    <= PH_PREP;
          aidx  <= '0;
          bdone <= '0;
        end
        S_WAIT: begin
          if (tcnt != '0) tcnt <= tcnt - 1'b1;
          else if (rb_n) begin
            st <= after_wait;
            ph <= PH_PREP;
          end else if (bsy == BW'(BUSY_MAX - 1)) begin
            err <= 1'b1;
            st  <= S_END;
          end else bsy <= bsy + 1'b1;
        end
        S_END: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: begin
          case (ph)
            PH_PREP: begin
              if (wr_dat && widx == 2'd0) begin
                if (!fifo_empty) ph <= PH_LOAD;
              end else begin
                ph   <= PH_LO;
                tcnt <= TW'(T_WLO - 1);
              end
            end
            PH_LOAD: begin
              sh   <= fifo_q;
              ph   <= PH_LO;
              tcnt <= TW'(T_WLO - 1);
            end
            PH_LO: begin
              if (tcnt != '0) tcnt <= tcnt - 1'b1;
              else begin
                ph   <= PH_HI;
                tcnt <= TW'(T_WHI - 1);
                if (rd_dat) asm_w <= {asm_w[23:0], dq_i};
              end
            end
            default: begin
              if (tcnt != '0) tcnt <= tcnt - 1'b1;
              else if (!(rd_dat && word_end && fifo_full)) begin
                ph <= PH_PREP;
                case (st)
                  S_CMD1: st <= to_addr;
                  S_CMD2: begin
                    st   <= S_WAIT;
                    tcnt <= TW'(T_WB - 1);
                    bsy  <= '0;
                  end
                  S_ADDR: begin
                    if (last_adr) st <= after_addr;
                    else aidx <= aidx + 1'b1;
                  end
                  default: begin
                    if (dir) sh <= {sh[23:0], 8'h00};
                    bdone <= bdone + 1'b1;
                    if (last_dat) st <= after_data;
                  end
                endcase
              end
            end
          endcase
        end
      endcase
    end
  end

  // registered pin decode
  logic strobe_lo, byte_out;
  assign byte_out  = (st == S_CMD1) || (st == S_CMD2) || (st == S_ADDR) || wr_dat;
  assign strobe_lo = (ph == PH_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      cle   <= 1'b0;
      ale   <= 1'b0;
      we_n  <= 1'b1;
      re_n  <= 1'b1;
      dq_o  <= '0;
      dq_oe <= 1'b0;
    end else begin
      cle   <= ((st == S_CMD1) || (st == S_CMD2)) && (ph == PH_LO || ph == PH_HI);
      ale   <= (st == S_ADDR) && (ph == PH_LO || ph == PH_HI);
      we_n  <= !(byte_out && strobe_lo);
      re_n  <= !(rd_dat && strobe_lo);
      dq_o  <= cur_byte;
      dq_oe <= byte_out && (ph == PH_LO || ph == PH_HI);
    end
  end

  AST_CMD_ADDR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n)); // R5
  AST_DATA_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == S_WAIT && st == S_DATA) |-> $past(rb_n)); // R11

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int T_WLO      = 3,
  parameter int T_WHI      = 2,
  parameter int T_WB       = 4,
  parameter int BUSY_MAX   = 100000,
  localparam int CNT_W     = 16,
  localparam int LW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb_n
);

  seq_cfg_t         cfg;
  logic             end_f, err_f, start_q;
  logic [15:0]      opc;
  logic [31:0]      adr;
  logic [7:0]       adr2;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      rd_q, fifo_q, eng_wdata;
  logic             rd_fifo_q;
  logic             eng_busy, eng_done, eng_err, eng_push, eng_pop;
  logic [LW-1:0]    level;
  logic             f_full, f_empty;
  logic             wr_ctrl;

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      end_f     <= 1'b0;
      err_f     <= 1'b0;
      start_q   <= 1'b0;
      opc       <= '0;
      adr       <= '0;
      adr2      <= '0;
      cnt       <= '0;
      nand_ce_n <= 1'b1;
    end else begin
      start_q   <= wr_ctrl && reg_wdata[0] && !eng_busy;
      nand_ce_n <= !cfg.ce;
      if (wr_ctrl) cfg <= reg_wdata[10:3];
      if (reg_we && reg_addr == RA_OPC)  opc  <= reg_wdata[15:0];
      if (reg_we && reg_addr == RA_ADR)  adr  <= reg_wdata;
      if (reg_we && reg_addr == RA_ADR2) adr2 <= reg_wdata[7:0];
      if (reg_we && reg_addr == RA_CNT)  cnt  <= reg_wdata[CNT_W-1:0];
      if (wr_ctrl && (reg_wdata == '0 || reg_wdata[0])) begin
        end_f <= 1'b0;
        err_f <= 1'b0;
      end else begin
        if (eng_done) end_f <= 1'b1;
        if (eng_err)  err_f <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      rd_fifo_q <= 1'b0;
    end else if (reg_re) begin
      rd_fifo_q <= (reg_addr == RA_FIFO);
      case (reg_addr)
        RA_CTRL: rd_q <= {21'd0, cfg, err_f, end_f, eng_busy | start_q};
        RA_OPC:  rd_q <= {16'd0, opc};
        RA_ADR:  rd_q <= adr;
        RA_ADR2: rd_q <= {24'd0, adr2};
        RA_CNT:  rd_q <= {8'd0, 8'(level), cnt};
        default: rd_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rd_fifo_q ? fifo_q : rd_q;

  nand_seq_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (reg_we && reg_addr == RA_CLR),
    .push  (eng_push || (reg_we && reg_addr == RA_FIFO)),
    .wdata (eng_push ? eng_wdata : reg_wdata),
    .pop   (eng_pop || (reg_re && reg_addr == RA_FIFO)),
    .rdata (fifo_q),
    .level (level),
    .full  (f_full),
    .empty (f_empty)
  );

  nand_seq_engine #(
    .T_WLO(T_WLO), .T_WHI(T_WHI), .T_WB(T_WB), .BUSY_MAX(BUSY_MAX), .CNT_W(CNT_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .start      (start_q),
    .cmd1_en    (cfg.cmd1_en),
    .addr_en    (cfg.addr_en),
    .cmd2_en    (cfg.cmd2_en),
    .dir        (cfg.dir),
    .acnt       (cfg.acnt),
    .five       (cfg.five),
    .opc        (opc),
    .adr        (adr),
    .adr2       (adr2),
    .cnt        (cnt),
    .rb_n       (nand_rb_n),
    .dq_i       (nand_dq_i),
    .fifo_q     (fifo_q),
    .fifo_empty (f_empty),
    .fifo_full  (f_full),
    .fifo_push  (eng_push),
    .fifo_wdata (eng_wdata),
    .fifo_pop   (eng_pop),
    .busy       (eng_busy),
    .done       (eng_done),
    .err        (eng_err),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .dq_o       (nand_dq_o),
    .dq_oe      (nand_dq_oe)
  );

  AST_END_STICKY: assert property (@(posedge clk) disable iff (rst)
    (end_f && !wr_ctrl) |=> end_f); // R7
  AST_CE_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg.ce) && $stable(cfg.ce)) |-> !nand_ce_n); // R10

endmodule

// File: tb/test_nand_seq_top.sv
module test_nand_seq_top;

  localparam int DEPTH = 8, BUSY_MAX = 64, TWLO = 2, TWHI = 1, TWB = 4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 0, reg_re = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i = '0;
  logic        nand_rb_n;

  always #2 clk = ~clk;

  nand_seq_top #(.FIFO_DEPTH(DEPTH), .T_WLO(TWLO), .T_WHI(TWHI), .T_WB(TWB),
                 .BUSY_MAX(BUSY_MAX)) i_nand_seq_top (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [9:0] act_log [64];
  int   log_n = 0, rd_idx = 0, busy_left = 0, busy_len = 2, txn_id = 0;
  bit   busy_arm = 0, cmd2_seen = 0, re_busy = 0, re_early = 0;
  logic [7:0] busy_opc = '0;
  logic we_prev = 1, re_prev = 1;

  assign nand_rb_n = (busy_left == 0);

  function automatic logic [7:0] rbyte(input int i, input int t);
    return 8'((i * 29) + (t * 13) + 7);
  endfunction

  always @(negedge clk) begin
    if (busy_left > 0) busy_left = busy_left - 1;
    if (!we_prev && nand_we_n) begin
      if (log_n < 64) act_log[log_n] = {nand_cle, nand_ale, nand_dq_o};
      log_n = log_n + 1;
      if (busy_arm && nand_cle && nand_dq_o == busy_opc) begin
        busy_left = busy_len;
        cmd2_seen = 1;
      end
    end
    if (re_prev && !nand_re_n) begin
      if (busy_left != 0) re_busy = 1;
      if (busy_arm && !cmd2_seen) re_early = 1;
      nand_dq_i = rbyte(rd_idx, txn_id);
      rd_idx = rd_idx + 1;
    end
    we_prev = nand_we_n;
    re_prev = nand_re_n;
  end

  // ---------------- host access ----------------
  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    reg_re = 0;
    d = reg_rdata;
  endtask

  // ---------------- one transaction ----------------
  task automatic run_txn(input bit c1, input bit a_en, input bit c2, input bit dir,
                         input int acnt, input bit five, input logic [15:0] opc,
                         input logic [31:0] adr, input logic [7:0] adr2, input int cnt,
                         input int blen, input bit exp_to, input bit keep_end);
    logic [31:0] wwords [8];
    logic [9:0]  exl [64];
    logic [31:0] v, ew;
    int en = 0, na, nw, guard;
    nw = (cnt + 3) / 4;
    na = five ? 5 : acnt + 1;
    if (dir) for (int w = 0; w < nw; w++) begin
      wwords[w] = $urandom;
      reg_wr(3'd5, wwords[w]);
    end
    if (c1) begin exl[en] = {2'b10, opc[7:0]}; en++; end
    if (a_en) for (int k = 0; k < na; k++) begin
      exl[en] = {2'b01, (k < 4) ? adr[8*k +: 8] : adr2}; en++;
    end
    if (dir) for (int i = 0; i < cnt; i++) begin
      exl[en] = {2'b00, wwords[i/4][31 - 8*(i%4) -: 8]}; en++;
    end
    if (c2) begin exl[en] = {2'b10, opc[15:8]}; en++; end
    reg_wr(3'd1, {16'd0, opc});
    reg_wr(3'd2, adr);
    reg_wr(3'd3, {24'd0, adr2});
    reg_wr(3'd4, cnt);
    txn_id++;
    busy_opc = opc[15:8]; busy_arm = c2; busy_len = blen;
    log_n = 0; rd_idx = 0; cmd2_seen = 0; re_busy = 0; re_early = 0;
    reg_wr(3'd0, {21'd0, five, 2'(acnt), dir, c2, a_en, c1, 1'b1, 3'b001});
    guard = 0;
    do begin reg_rd(3'd0, v); guard++; end while (!v[1] && guard < 3000);
    chk(v[1] == 1'b1, "R7 end flag set", v, 32'h2);
    chk(v[2] == exp_to, "R11 timeout flag", v[2], exp_to);
    if (!exp_to) chk(busy_left == 0, "R11 end only when ready", busy_left, 0);
    chk(log_n == en, "R2 strobed byte count", log_n, en);
    for (int i = 0; i < en && i < log_n; i++)
      chk(act_log[i] == exl[i],
          exl[i][9] ? "R3 command byte" : (exl[i][8] ? "R4 address byte" : "R9 write data byte"),
          act_log[i], exl[i]);
    chk(rd_idx == ((dir || exp_to) ? 0 : cnt), "R6 read strobe count", rd_idx,
        (dir || exp_to) ? 0 : cnt);
    chk(!re_busy && !re_early, "R5 R11 read data after confirm and ready",
        {re_busy, re_early}, 0);
    if (!dir && !exp_to) for (int w = 0; w < nw; w++) begin
      ew = '0;
      for (int j = 0; j < 4; j++)
        if (4*w + j < cnt) ew[31 - 8*j -: 8] = rbyte(4*w + j, txn_id);
      reg_rd(3'd5, v);
      chk(v == ew, "R9 read word packing", v, ew);
    end
    reg_rd(3'd4, v);
    chk(v[23:16] == 8'd0, "R8 FIFO drained", v[23:16], 0);
    if (!keep_end) reg_wr(3'd0, 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] v, w0, w1;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R1 idle pins",
        {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
    reg_rd(3'd0, v); chk(v == 0, "R1 control reset", v, 0);
    reg_rd(3'd4, v); chk(v[23:16] == 0, "R1 level reset", v[23:16], 0);

    // R10 chip enable
    reg_wr(3'd0, 32'h8); @(negedge clk);
    chk(nand_ce_n == 1'b0, "R10 CE asserted", nand_ce_n, 0);
    reg_wr(3'd0, 32'h0); @(negedge clk);
    chk(nand_ce_n == 1'b1, "R10 CE released", nand_ce_n, 1);

    // R8 FIFO level, order, clear
    reg_wr(3'd5, 32'h11); reg_wr(3'd5, 32'h22); reg_wr(3'd5, 32'h33);
    reg_rd(3'd4, v); chk(v[23:16] == 3, "R8 level after pushes", v[23:16], 3);
    reg_wr(3'd6, 32'h0);
    reg_rd(3'd4, v); chk(v[23:16] == 0, "R8 level after clear", v[23:16], 0);
    reg_wr(3'd5, 32'hA5A5_0001); reg_wr(3'd5, 32'hA5A5_0002);
    reg_rd(3'd5, w0); reg_rd(3'd5, w1);
    chk(w0 == 32'hA5A5_0001 && w1 == 32'hA5A5_0002, "R8 FIFO order", {w0, w1},
        {32'hA5A5_0001, 32'hA5A5_0002});

    // directed: page read, program with 5 addr bytes, erase, reset, status
    run_txn(1, 1, 1, 0, 3, 0, 16'h3000, 32'h0403_0201, 8'h05, 8, 6, 0, 0);   // R4 4 bytes
    run_txn(1, 1, 1, 1, 0, 1, 16'h1080, 32'hDDCC_BBAA, 8'hEE, 6, 5, 0, 0);   // R4 5 bytes, R5 write
    run_txn(1, 1, 1, 0, 2, 0, 16'hD060, 32'h0012_3456, 8'h00, 0, 9, 0, 0);   // R6 count zero
    run_txn(1, 0, 0, 0, 0, 0, 16'h00FF, 32'h0, 8'h0, 0, 2, 0, 0);            // R2 skip phases
    run_txn(1, 0, 0, 0, 0, 0, 16'h0070, 32'h0, 8'h0, 1, 2, 0, 1);            // R9 partial word

    // R7 end sticky through nonzero write, cleared by zero
    reg_wr(3'd0, 32'h8);
    reg_rd(3'd0, v); chk(v[1] == 1'b1, "R7 end kept on nonzero write", v[1], 1);
    reg_wr(3'd0, 32'h0);
    reg_rd(3'd0, v); chk(v[1] == 1'b0, "R7 end cleared by zero write", v[1], 0);

    // R11 busy timeout: data phase skipped, error flag set
    run_txn(1, 1, 1, 0, 1, 0, 16'h3000, 32'h0000_0707, 8'h0, 4, 1000, 1, 0);
    repeat (1000) @(negedge clk);

    // constrained random
    for (int t = 0; t < 40; t++) begin
      bit rc1, ra, rc2, rd, r5;
      int rac, rcnt;
      rc1 = 1'($urandom); ra = 1'($urandom); rc2 = 1'($urandom); rd = 1'($urandom);
      r5 = ($urandom % 4) == 0; rac = $urandom % 4; rcnt = $urandom % 21;
      run_txn(rc1, ra, rc2, rd, rac, r5, 16'($urandom), $urandom, 8'($urandom), rcnt,
              2 + ($urandom % 20), 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule